// File: doc/BRIEF.md
# Digital Soft-Start and Power-Good Sequencer

This block brings a step-down converter up in a controlled way. It advances only on clock edges where the switching-cycle tick is high. Once both the supply-good and enable inputs are high, it holds the digital reference code at zero for a fixed number of switching cycles. It then raises the code by one step per switching cycle until the code reaches full scale, and keeps it there.

While the reference climbs, the block raises an undervoltage-enable flag once the code passes 80% of full scale. From that point the external fault logic may act on low output voltage. A short, fixed number of cycles after the ramp ends, the block releases power-good, gated at all times by an output-in-window input from the external comparators. The fault supervisor can send a restart request during soft-start, for example when an undervoltage shows that the input supply is absent. A restart sends the sequence back to the start of the initial delay with the reference at zero.

Top module: `softstart_seq`

## Requirements
- R1: The sequence starts on the first tick edge at which `supply_ok` and `enable` are both high. Until then `ss_active`, `uv_en` and `pgood` stay low and `ref_code` is 0.
- R2: After the start edge, `ref_code` stays 0 for exactly `DELAY_CYC` ticks (1024 by default).
- R3: The ramp then follows. `ref_code` is 0 in the first ramp tick period and rises by exactly 1 at each tick edge. It reaches all-ones (1023 by default) after 2^`CODE_W`−1 ticks, so the ramp spans 2^`CODE_W` tick periods, and the code then holds at all-ones.
- R4: On clock edges where `tick` is low, neither the reference nor the sequence advances.
- R5: `uv_en` is high exactly when the sequence is running and `ref_code` ≥ floor((2^`CODE_W`−1)·`UV_PCT`/100) (818 by default, 24 at `CODE_W`=5). Once set, it stays high until the sequence is reset.
- R6: `ss_active` is high from the start edge until the tick edge that ends the ramp, and low otherwise.
- R7: Power-good is released `PG_DELAY` ticks (3 by default) after the ramp ends. `pgood` is high only while released and `win_ok` is high.
- R8: `pgood` follows `win_ok` without delay. It goes low in the same cycle that the external window comparators (+12.5% / −25% around the reference) report the output out of window, and returns when `win_ok` returns.
- R9: A `restart_req` high at a clock edge during soft-start (`ss_active` high) returns the block to the first cycle of the initial delay with `ref_code` 0. A request while idle or after the ramp has no effect.
- R10: When `supply_ok` or `enable` is low at a clock edge, the block goes idle at that edge. `ref_code` becomes 0 and `ss_active`, `uv_en` and `pgood` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe per switching cycle |
| supply_ok | input | 1 | Supplies above their under-voltage lockout |
| enable | input | 1 | Converter enable |
| restart_req | input | 1 | Restart request from the fault supervisor |
| win_ok | input | 1 | Output voltage inside the power-good window |
| ref_code | output | CODE_W | Digital reference code |
| ss_active | output | 1 | Soft-start (delay or ramp) in progress |
| uv_en | output | 1 | Undervoltage checking may be enabled |
| pgood | output | 1 | Power-good |

## Verification
The bench builds the block with `DELAY_CYC`=16, `CODE_W`=5, `UV_PCT`=80 and `PG_DELAY`=3, and applies a tick on every second clock. With these values the full sequence completes in 52 ticks. The bench can then check each boundary tick: the last delay tick, the 23→24 threshold crossing, the ramp end at 31 and the power-good release one tick after the release is still held off. The idle clocks between ticks show that nothing advances without a tick, and a restart in mid-ramp can be followed through a complete second delay.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  typedef enum logic [2:0] {
    SS_IDLE,
    SS_DELAY,
    SS_RAMP,
    SS_PGWAIT,
    SS_DONE
  } ss_state_e;

  // Code at which undervoltage checking opens: floor(full * pct / 100)
  function automatic int unsigned uv_threshold(int unsigned full, int unsigned pct);
    return (full * pct) / 100;
  endfunction

  // Bits needed to count from 0 to the larger of two limits
  function automatic int unsigned count_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/ss_phase_ctrl.sv
module ss_phase_ctrl
  import softstart_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 1024,
  parameter int unsigned PG_DELAY  = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      go,
  input  logic      restart_req,
  input  logic      ramp_last,
  output ss_state_e state,
  output logic      go_lost,
  output logic      restart_hit,
  output logic      delay_done,
  output logic      ramp_done,
  output logic      pgw_done
);

  localparam int unsigned CNT_W = count_width(DELAY_CYC, PG_DELAY);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] PGW_LAST = CNT_W'(PG_DELAY - 1);

  ss_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_soft;

  assign in_soft     = (state_q == SS_DELAY) || (state_q == SS_RAMP);
  assign go_lost     = !go && (state_q != SS_IDLE);
  assign restart_hit = go && restart_req && in_soft;
  assign delay_done  = tick && (state_q == SS_DELAY)  && (cnt_q == DLY_LAST);
  assign ramp_done   = tick && (state_q == SS_RAMP)   && ramp_last;
  assign pgw_done    = tick && (state_q == SS_PGWAIT) && (cnt_q == PGW_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (go_lost) begin
      state_d = SS_IDLE;
      cnt_d   = '0;
    end else if (restart_hit) begin
      state_d = SS_DELAY;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        SS_IDLE: begin
          if (go) state_d = SS_DELAY;
          cnt_d = '0;
        end
        SS_DELAY: begin
          if (delay_done) begin
            state_d = SS_RAMP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SS_RAMP: begin
          if (ramp_done) state_d = SS_PGWAIT;
          cnt_d = '0;
        end
        SS_PGWAIT: begin
          if (pgw_done) begin
            state_d = SS_DONE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SS_DONE: cnt_d = '0;
        default: begin
          state_d = SS_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/ss_ref_ramp.sv
module ss_ref_ramp #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [CODE_W-1:0] ref_code,
  output logic              at_max
);

  logic [CODE_W-1:0] code_q;

  assign at_max = &code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (clr) begin
      code_q <= '0;
    end else if (step && !at_max) begin
      code_q <= code_q + 1'b1;
    end
  end

  assign ref_code = code_q;

endmodule

// File: rtl/ss_status.sv
module ss_status
  import softstart_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned UV_PCT = 80
) (
  input  ss_state_e         state,
  input  logic [CODE_W-1:0] ref_code,
  input  logic              win_ok,
  output logic              ss_active,
  output logic              uv_en,
  output logic              pgood
);

  localparam int unsigned       FULL   = (1 << CODE_W) - 1;
  localparam logic [CODE_W-1:0] UV_THR = CODE_W'(uv_threshold(FULL, UV_PCT));

  logic running;

  assign running   = (state == SS_RAMP) || (state == SS_PGWAIT) || (state == SS_DONE);
  assign ss_active = (state == SS_DELAY) || (state == SS_RAMP);
  assign uv_en     = running && (ref_code >= UV_THR);
  assign pgood     = (state == SS_DONE) && win_ok;

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 1024,
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned UV_PCT    = 80,
  parameter int unsigned PG_DELAY  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              supply_ok,
  input  logic              enable,
  input  logic              restart_req,
  input  logic              win_ok,
  output logic [CODE_W-1:0] ref_code,
  output logic              ss_active,
  output logic              uv_en,
  output logic              pgood
);

  ss_state_e state;
  logic      go, go_lost, restart_hit;
  logic      delay_done, ramp_done, pgw_done;
  logic      at_max, ref_clr, ref_step;

  assign go = supply_ok && enable;

  ss_phase_ctrl #(
    .DELAY_CYC(DELAY_CYC),
    .PG_DELAY (PG_DELAY)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .go         (go),
    .restart_req(restart_req),
    .ramp_last  (at_max),
    .state      (state),
    .go_lost    (go_lost),
    .restart_hit(restart_hit),
    .delay_done (delay_done),
    .ramp_done  (ramp_done),
    .pgw_done   (pgw_done)
  );

  assign ref_clr  = go_lost || restart_hit || (state == SS_IDLE) || (state == SS_DELAY);
  assign ref_step = tick && (state == SS_RAMP);

  ss_ref_ramp #(
    .CODE_W(CODE_W)
  ) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ref_clr),
    .step    (ref_step),
    .ref_code(ref_code),
    .at_max  (at_max)
  );

  ss_status #(
    .CODE_W(CODE_W),
    .UV_PCT(UV_PCT)
  ) u_status (
    .state    (state),
    .ref_code (ref_code),
    .win_ok   (win_ok),
    .ss_active(ss_active),
    .uv_en    (uv_en),
    .pgood    (pgood)
  );

endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk
  import softstart_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned UV_PCT = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              supply_ok,
  input logic              enable,
  input logic              restart_req,
  input logic              win_ok,
  input logic [CODE_W-1:0] ref_code,
  input logic              ss_active,
  input logic              uv_en,
  input logic              pgood
);

  localparam logic [CODE_W-1:0] THR = CODE_W'(uv_threshold((1 << CODE_W) - 1, UV_PCT));

  // R3
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ref_code == $past(ref_code) || ref_code == $past(ref_code) + 1'b1 || ref_code == '0));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && supply_ok && enable && !restart_req) |=> $stable(ref_code));

  // R5
  uv_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_en |-> (ref_code >= THR));

  // R7
  pgood_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (win_ok && !ss_active && (&ref_code) && uv_en));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req && ss_active && supply_ok && enable) |=> (ref_code == '0 && ss_active && !uv_en));

  // R10
  go_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(supply_ok && enable) |=> (ref_code == '0 && !ss_active && !pgood && !uv_en));

endmodule

bind softstart_seq softstart_seq_chk #(
  .CODE_W(CODE_W),
  .UV_PCT(UV_PCT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .supply_ok  (supply_ok),
  .enable     (enable),
  .restart_req(restart_req),
  .win_ok     (win_ok),
  .ref_code   (ref_code),
  .ss_active  (ss_active),
  .uv_en      (uv_en),
  .pgood      (pgood)
);

// File: tb/softstart_seq_bench.sv
module softstart_seq_bench;

  localparam int unsigned DLY  = 16;
  localparam int unsigned CW   = 5;
  localparam int unsigned PCT  = 80;
  localparam int unsigned PGD  = 3;
  localparam int unsigned FULL = (1 << CW) - 1;   // 31
  localparam int unsigned THR  = (FULL * PCT) / 100; // 24

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          supply_ok = 1'b0;
  logic          enable = 1'b0;
  logic          restart_req = 1'b0;
  logic          win_ok = 1'b1;
  logic [CW-1:0] ref_code;
  logic          ss_active, uv_en, pgood;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  softstart_seq #(
    .DELAY_CYC(DLY),
    .CODE_W   (CW),
    .UV_PCT   (PCT),
    .PG_DELAY (PGD)
  ) u_softstart_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .supply_ok  (supply_ok),
    .enable     (enable),
    .restart_req(restart_req),
    .win_ok     (win_ok),
    .ref_code   (ref_code),
    .ss_active  (ss_active),
    .uv_en      (uv_en),
    .pgood      (pgood)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_edges(int n);
    for (int i = 0; i < n;) begin
      @(posedge clk);
      if (tick) i++;
    end
    #1;
  endtask

  task automatic pulse_restart();
    restart_req = 1'b1;
    @(posedge clk);
    #1;
    restart_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset ref", ref_code, 0);
    check("R1 reset ss_active", ss_active, 0);
    check("R1 reset uv_en", uv_en, 0);
    check("R1 reset pgood", pgood, 0);
  endtask

  task automatic t_no_start();
    enable = 1'b1;
    tick_edges(5);
    check("R1 no start without supply_ok", ss_active, 0);
    pulse_restart();
    tick_edges(2);
    check("R9 restart while idle ignored", ss_active, 0);
  endtask

  task automatic t_full_seq();
    supply_ok = 1'b1;
    tick_edges(1);
    check("R1 start edge ss_active", ss_active, 1);
    tick_edges(15);
    check("R2 last delay tick ref", ref_code, 0);
    tick_edges(1);
    check("R2 ramp start ref", ref_code, 0);
    tick_edges(5);
    check("R3 ramp ref 5", ref_code, 5);
    @(posedge clk); #1;
    check("R4 no advance without tick", ref_code, 5);
    tick_edges(18);
    check("R5 uv_en below threshold", uv_en, 0);
    check("R5 ref one below threshold", ref_code, THR - 1);
    tick_edges(1);
    check("R5 uv_en at threshold", uv_en, 1);
    tick_edges(7);
    check("R3 ref at full scale", ref_code, FULL);
    check("R6 ss_active through last ramp tick", ss_active, 1);
    tick_edges(1);
    check("R6 ss_active low after ramp", ss_active, 0);
    check("R3 ref holds full scale", ref_code, FULL);
    tick_edges(2);
    check("R7 pgood held before delay expires", pgood, 0);
    tick_edges(1);
    check("R7 pgood released", pgood, 1);
    tick_edges(4);
    check("R3 ref still full scale", ref_code, FULL);
    check("R5 uv_en stays high", uv_en, 1);
  endtask

  task automatic t_window();
    win_ok = 1'b0; #1;
    check("R8 pgood drops with window", pgood, 0);
    win_ok = 1'b1; #1;
    check("R8 pgood returns with window", pgood, 1);
  endtask

  task automatic t_restart_late();
    pulse_restart();
    check("R9 restart after ramp ignored ref", ref_code, FULL);
    check("R9 restart after ramp ignored pgood", pgood, 1);
  endtask

  task automatic t_enable_drop();
    enable = 1'b0;
    @(posedge clk); #1;
    check("R10 enable drop ref", ref_code, 0);
    check("R10 enable drop ss_active", ss_active, 0);
    check("R10 enable drop pgood", pgood, 0);
    check("R10 enable drop uv_en", uv_en, 0);
  endtask

  task automatic t_restart_ramp();
    enable = 1'b1;
    tick_edges(30);
    check("R3 second ramp ref 13", ref_code, 13);
    pulse_restart();
    check("R9 restart clears ref", ref_code, 0);
    check("R9 restart keeps ss_active", ss_active, 1);
    tick_edges(16);
    check("R9 full delay rerun", ref_code, 0);
    tick_edges(5);
    check("R9 ramp resumes from zero", ref_code, 5);
    supply_ok = 1'b0;
    @(posedge clk); #1;
    check("R10 supply drop ref", ref_code, 0);
    check("R10 supply drop ss_active", ss_active, 0);
  endtask

  task automatic t_window_at_release();
    win_ok = 1'b0;
    supply_ok = 1'b1;
    tick_edges(52);
    check("R7 no pgood while out of window", pgood, 0);
    check("R7 ramp finished", ref_code, FULL);
    win_ok = 1'b1; #1;
    check("R7 pgood once window ok", pgood, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_no_start();
    t_full_seq();
    t_window();
    t_restart_late();
    t_enable_drop();
    t_restart_ramp();
    t_window_at_release();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule